// File: doc/BRIEF.md
# Signed Decimal Field Comparator

This block compares two equal-length operands that arrive one unit per cycle, most significant unit first, and reports whether operand A ranks HIGH, EQUAL or LOW against operand B. A comparison begins with a one-cycle `start` carrying the field length and the operand mode. The units then follow on `a_unit` and `b_unit`, one pair each cycle that `unit_valid` is high. One cycle after the final pair is taken, `done` pulses. The result code and the invalid flag then stay put until the next `start`.

There are three modes. The first is unsigned decimal, with 4-bit digits. The second is signed decimal: one extra leading unit holds the sign, and only the code 1101 means minus. Every other sign code means plus, and plus ranks above minus. In the decimal modes only the low nibble of each unit is used. A magnitude digit above 9 in either operand marks the result as not valid. The third mode compares 8-bit characters as plain unsigned binary values and has no sign unit.

Top module: `dec_field_cmp`

## Requirements
- R1: After a synchronous reset, `done` is 0, `result` is 2'b00 and `invalid` is 0.
- R2: The result code is 2'b10 when A ranks above B, 2'b01 when A ranks below B and 2'b00 when they are equal. In unsigned decimal mode (`mode` = 2'b00), the first magnitude digit pair that differs decides the result, scanning from the most significant digit.
- R3: `done` is high for exactly one cycle, in the cycle after the clock edge that takes the last unit pair. `result` and `invalid` then hold until the next `start`.
- R4: In signed decimal mode (`mode` = 2'b01) the first pair taken holds the signs in the low nibbles. Code 4'hD means negative and all other codes mean positive. When the signs differ, the positive operand ranks HIGH, unless both magnitudes are zero, in which case the result is EQUAL.
- R5: In signed decimal mode, when both signs are negative, the magnitude ordering is reversed before it is reported.
- R6: In either decimal mode, a magnitude digit above 9 in either operand sets `invalid` and forces `result` to 2'b11. A sign unit never sets `invalid`.
- R7: In character mode (`mode[1]` = 1) each unit is a full 8-bit code, compared as an unsigned binary number. There is no sign unit and `invalid` stays 0.
- R8: `length` gives the number of magnitude units. A value of 0 is treated as 1, and a value above 100 is treated as 100.
- R9: Unit pairs are ignored while `unit_valid` is low, while no comparison is running, and in a cycle where `start` is high. A new `start` abandons any comparison in progress.
- R10: In the decimal modes, the upper nibble of each unit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a comparison and latches length and mode |
| length | input | 7 | Number of magnitude units (1 to 100) |
| mode | input | 2 | 00 unsigned decimal, 01 signed decimal, 1x character |
| unit_valid | input | 1 | A unit pair is present on a_unit and b_unit |
| a_unit | input | 8 | Operand A unit |
| b_unit | input | 8 | Operand B unit |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 equal, 01 A low, 10 A high, 11 not valid |
| invalid | output | 1 | An undigit was seen in a decimal magnitude |

## Verification
The assertions check the timing rules on every cycle. `done` never lasts longer than one cycle, and it always follows a pair that was accepted with no `start` in the same cycle. A `start` clears the outputs. The not-valid code appears exactly when `invalid` is set at completion. The ordering itself cannot be checked cycle by cycle, so only the bench scenarios show it. That covers sign ranking, the equal result for zero magnitudes with opposite signs, reversal when both signs are negative, binary order of characters, length clamping and the handling of ignored units. The bench checks these by sweeping digit, sign and character values and comparing each result with the arithmetic order of the operands.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    localparam int DFC_MAX_LEN  = 100;
    localparam int DFC_UNIT_W   = 8;
    localparam int DFC_DIG_W    = 4;
    localparam int DFC_DIG_MAX  = 9;
    localparam logic [3:0] DFC_MINUS = 4'hD;

    typedef enum logic [1:0] {
        RES_EQ  = 2'b00,
        RES_LO  = 2'b01,
        RES_HI  = 2'b10,
        RES_BAD = 2'b11
    } cmp_res_e;

    typedef enum logic [1:0] {
        MODE_UN = 2'b00,
        MODE_SN = 2'b01,
        MODE_AL = 2'b10
    } field_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_SIGN = 2'b01,
        PH_MAG  = 2'b10
    } phase_e;

    function automatic field_mode_e decode_mode(input logic [1:0] m);
        if (m[1])
            return MODE_AL;
        else if (m[0])
            return MODE_SN;
        else
            return MODE_UN;
    endfunction

    function automatic logic is_minus(input logic [3:0] s);
        return s == DFC_MINUS;
    endfunction

    function automatic cmp_res_e flip_res(input cmp_res_e r);
        case (r)
            RES_HI:  return RES_LO;
            RES_LO:  return RES_HI;
            default: return r;
        endcase
    endfunction

endpackage

// File: rtl/dfc_seq.sv
module dfc_seq
    import dfc_pkg::*;
#(
    parameter int MAX_LEN = DFC_MAX_LEN,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    input  logic [1:0]       mode_in,
    input  logic             unit_valid,
    output field_mode_e      mode_q,
    output logic             sign_take,
    output logic             mag_take,
    output logic             done_q
);
    phase_e           phase;
    logic [LEN_W-1:0] remain;
    logic [LEN_W-1:0] len_eff;
    field_mode_e      mode_new;

    always_comb begin
        if (len_in == '0)
            len_eff = LEN_W'(1);
        else if (len_in > LEN_W'(MAX_LEN))
            len_eff = LEN_W'(MAX_LEN);
        else
            len_eff = len_in;
    end

    assign mode_new  = decode_mode(mode_in);
    assign sign_take = (phase == PH_SIGN) && unit_valid && !start;
    assign mag_take  = (phase == PH_MAG) && unit_valid && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            remain <= '0;
            mode_q <= MODE_UN;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                mode_q <= mode_new;
                remain <= len_eff;
                phase  <= (mode_new == MODE_SN) ? PH_SIGN : PH_MAG;
            end else if (sign_take) begin
                phase <= PH_MAG;
            end else if (mag_take) begin
                remain <= remain - LEN_W'(1);
                if (remain == LEN_W'(1)) begin
                    phase  <= PH_IDLE;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dfc_sign.sv
module dfc_sign
    import dfc_pkg::*;
#(
    parameter int DIG_W = DFC_DIG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic [DIG_W-1:0] a_sign,
    input  logic [DIG_W-1:0] b_sign,
    output logic             a_neg,
    output logic             b_neg
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            a_neg <= 1'b0;
            b_neg <= 1'b0;
        end else if (take) begin
            a_neg <= is_minus(4'(a_sign));
            b_neg <= is_minus(4'(b_sign));
        end
    end
endmodule

// File: rtl/dfc_mag.sv
module dfc_mag
    import dfc_pkg::*;
#(
    parameter int UNIT_W = DFC_UNIT_W,
    parameter int DIG_W  = DFC_DIG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  field_mode_e       mode,
    input  logic [UNIT_W-1:0] a_unit,
    input  logic [UNIT_W-1:0] b_unit,
    output cmp_res_e          mag_res,
    output logic              a_nz,
    output logic              b_nz,
    output logic              bad
);
    localparam logic [DIG_W-1:0] DIG_LIMIT = DIG_W'(DFC_DIG_MAX);

    logic [DIG_W-1:0] a_dig, b_dig;
    logic             numeric;
    cmp_res_e         step_res;

    assign a_dig   = a_unit[DIG_W-1:0];
    assign b_dig   = b_unit[DIG_W-1:0];
    assign numeric = (mode != MODE_AL);

    always_comb begin
        step_res = RES_EQ;
        if (numeric) begin
            if (a_dig > b_dig)
                step_res = RES_HI;
            else if (a_dig < b_dig)
                step_res = RES_LO;
        end else begin
            if (a_unit > b_unit)
                step_res = RES_HI;
            else if (a_unit < b_unit)
                step_res = RES_LO;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mag_res <= RES_EQ;
            a_nz    <= 1'b0;
            b_nz    <= 1'b0;
            bad     <= 1'b0;
        end else if (take) begin
            if (mag_res == RES_EQ)
                mag_res <= step_res;
            a_nz <= a_nz || (a_dig != '0);
            b_nz <= b_nz || (b_dig != '0);
            bad  <= bad || (numeric && ((a_dig > DIG_LIMIT) || (b_dig > DIG_LIMIT)));
        end
    end
endmodule

// File: rtl/dfc_resolve.sv
module dfc_resolve
    import dfc_pkg::*;
(
    input  field_mode_e mode,
    input  cmp_res_e    mag_res,
    input  logic        a_neg,
    input  logic        b_neg,
    input  logic        a_nz,
    input  logic        b_nz,
    input  logic        bad,
    output cmp_res_e    final_res
);
    always_comb begin
        if (bad)
            final_res = RES_BAD;
        else if (mode != MODE_SN)
            final_res = mag_res;
        else if (a_neg != b_neg)
            final_res = (!a_nz && !b_nz) ? RES_EQ : (a_neg ? RES_LO : RES_HI);
        else if (a_neg)
            final_res = flip_res(mag_res);
        else
            final_res = mag_res;
    end
endmodule

// File: rtl/dec_field_cmp.sv
module dec_field_cmp
    import dfc_pkg::*;
#(
    parameter int  MAX_LEN = DFC_MAX_LEN,
    parameter int  UNIT_W  = DFC_UNIT_W,
    parameter int  DIG_W   = DFC_DIG_W,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  length,
    input  logic [1:0]        mode,
    input  logic              unit_valid,
    input  logic [UNIT_W-1:0] a_unit,
    input  logic [UNIT_W-1:0] b_unit,
    output logic              done,
    output logic [1:0]        result,
    output logic              invalid
);
    field_mode_e mode_q;
    logic        sign_take, mag_take;
    logic        a_neg, b_neg, a_nz, b_nz, bad;
    cmp_res_e    mag_res, final_res;

    dfc_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .len_in(length), .mode_in(mode),
        .unit_valid(unit_valid), .mode_q(mode_q), .sign_take(sign_take),
        .mag_take(mag_take), .done_q(done)
    );

    dfc_sign #(.DIG_W(DIG_W)) u_sign (
        .clk(clk), .rst(rst), .clear(start), .take(sign_take),
        .a_sign(a_unit[DIG_W-1:0]), .b_sign(b_unit[DIG_W-1:0]),
        .a_neg(a_neg), .b_neg(b_neg)
    );

    dfc_mag #(.UNIT_W(UNIT_W), .DIG_W(DIG_W)) u_mag (
        .clk(clk), .rst(rst), .clear(start), .take(mag_take), .mode(mode_q),
        .a_unit(a_unit), .b_unit(b_unit), .mag_res(mag_res),
        .a_nz(a_nz), .b_nz(b_nz), .bad(bad)
    );

    dfc_resolve u_resolve (
        .mode(mode_q), .mag_res(mag_res), .a_neg(a_neg), .b_neg(b_neg),
        .a_nz(a_nz), .b_nz(b_nz), .bad(bad), .final_res(final_res)
    );

    assign result  = final_res;
    assign invalid = bad;
endmodule

// File: rtl/dec_field_cmp_chk.sv
module dec_field_cmp_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       unit_valid,
    input logic       done,
    input logic [1:0] result,
    input logic       invalid
);
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_unit_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(unit_valid) && !$past(start)));

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !invalid));

    assert_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
        (done && invalid) |-> (result == 2'b11));

    assert_clean_code_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !invalid) |-> (result != 2'b11));
endmodule

bind dec_field_cmp dec_field_cmp_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .unit_valid(unit_valid),
    .done(done), .result(result), .invalid(invalid)
);

// File: tb/test_dec_field_cmp.sv
module test_dec_field_cmp;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [6:0] length;
    logic [1:0] mode;
    logic       unit_valid;
    logic [7:0] a_unit, b_unit;
    logic       done;
    logic [1:0] result;
    logic       invalid;

    always #2 clk = ~clk;

    dec_field_cmp i_dec_field_cmp (
        .clk(clk), .rst(rst), .start(start), .length(length), .mode(mode),
        .unit_valid(unit_valid), .a_unit(a_unit), .b_unit(b_unit),
        .done(done), .result(result), .invalid(invalid)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ua [0:127];
    logic [7:0] ub [0:127];
    logic       got_done;
    logic [1:0] got_res;
    logic       got_inv;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ord(input int a, input int b);
        return (a > b) ? 2 : ((a < b) ? 1 : 0);
    endfunction

    task automatic begin_op(input logic [1:0] md, input int lenf);
        @(negedge clk);
        start = 1'b1; length = 7'(lenf); mode = md; unit_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input logic [7:0] a, input logic [7:0] b, input int gap);
        for (int g = 0; g < gap; g++) begin
            unit_valid = 1'b0; a_unit = 8'h5A; b_unit = 8'hA5;
            @(negedge clk);
        end
        a_unit = a; b_unit = b; unit_valid = 1'b1;
        @(negedge clk);
        unit_valid = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] md, input int lenf, input int nunits,
                         input int gap);
        begin_op(md, lenf);
        for (int i = 0; i < nunits; i++) send(ua[i], ub[i], gap);
        got_done = done; got_res = result; got_inv = invalid;
    endtask

    task automatic expect_op(input string req, input int exp_res, input bit exp_inv);
        check(got_done === 1'b1 && got_res == 2'(exp_res) && got_inv == exp_inv, req,
              "done/result/invalid", {got_done, got_inv, got_res},
              {1'b1, exp_inv, 2'(exp_res)});
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "WATCHDOG", "timeout", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; length = '0; mode = '0; unit_valid = 1'b0;
        a_unit = '0; b_unit = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0 && result == 2'b00 && invalid == 1'b0, "R1", "reset outputs",
              {done, invalid, result}, 0);
        rst = 1'b0;

        // R2, R10: unsigned two-digit sweep with noisy upper nibbles
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                ua[0] = {4'(a * 7), 4'(a / 10)}; ua[1] = {4'(b * 3), 4'(a % 10)};
                ub[0] = {4'(a + b), 4'(b / 10)}; ub[1] = {4'(b), 4'(b % 10)};
                do_op(2'b00, 2, 2, 0);
                expect_op("R2_R10", ord(a, b), 1'b0);
            end
        end

        // R3: done lasts one cycle and the result holds
        ua[0] = 8'h07; ub[0] = 8'h02;
        do_op(2'b00, 1, 1, 0);
        expect_op("R3", 2, 1'b0);
        @(negedge clk);
        check(done == 1'b0 && result == 2'b10, "R3", "after pulse", {done, result}, 2);
        repeat (3) @(negedge clk);
        check(result == 2'b10, "R3", "result held", result, 2);

        // R6: single nibble sweep including undigits
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                ua[0] = 8'(a); ub[0] = 8'(b);
                do_op(2'b00, 1, 1, 0);
                if (a > 9 || b > 9) expect_op("R6", 3, 1'b1);
                else expect_op("R2", ord(a, b), 1'b0);
            end
        end

        // R4, R5, R6: every sign pair against small magnitudes, with gaps (R9)
        for (int sa = 0; sa < 16; sa++) begin
            for (int sb = 0; sb < 16; sb++) begin
                for (int ma = 0; ma < 10; ma += 4) begin
                    for (int mb = 0; mb < 10; mb += 4) begin
                        int va, vb;
                        ua[0] = 8'(sa); ub[0] = 8'(sb);
                        ua[1] = 8'(ma); ub[1] = 8'(mb);
                        va = (sa == 13) ? -ma : ma;
                        vb = (sb == 13) ? -mb : mb;
                        do_op(2'b01, 1, 2, sa % 3);
                        expect_op("R4_R9", ord(va, vb), 1'b0);
                    end
                end
            end
        end

        // R5: three-digit magnitudes, both negative
        for (int a = 0; a < 1000; a += 37) begin
            for (int b = 0; b < 1000; b += 53) begin
                ua[0] = 8'h0D; ub[0] = 8'h0D;
                ua[1] = 8'(a / 100); ua[2] = 8'((a / 10) % 10); ua[3] = 8'(a % 10);
                ub[1] = 8'(b / 100); ub[2] = 8'((b / 10) % 10); ub[3] = 8'(b % 10);
                do_op(2'b01, 3, 4, 0);
                expect_op("R5", ord(-a, -b), 1'b0);
            end
        end

        // R7: character mode, one byte
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 17) begin
                ua[0] = 8'(a); ub[0] = 8'(b);
                do_op(2'b10, 1, 1, 0);
                expect_op("R7", ord(a, b), 1'b0);
            end
        end

        // R7: character mode, three bytes, mode code 11
        for (int i = 0; i < 64; i++) begin
            int va, vb;
            va = (i * 40503 + 977) & 24'hFFFFFF;
            vb = va ^ (1 << (i % 24));
            if (i % 5 == 0) vb = va;
            for (int k = 0; k < 3; k++) begin
                ua[k] = 8'(va >> (16 - 8 * k));
                ub[k] = 8'(vb >> (16 - 8 * k));
            end
            do_op(2'b11, 3, 3, i % 2);
            expect_op("R7", ord(va, vb), 1'b0);
        end

        // R8: length 0 acts as 1
        ua[0] = 8'h05; ub[0] = 8'h03;
        do_op(2'b00, 0, 1, 0);
        expect_op("R8", 2, 1'b0);

        // R8: length 127 acts as 100
        begin_op(2'b00, 127);
        for (int i = 0; i < 99; i++) send(8'h04, 8'h04, 0);
        check(done == 1'b0, "R8", "done after 99 units", done, 0);
        send(8'h01, 8'h00, 0);
        check(done == 1'b1 && result == 2'b10, "R8", "done after 100 units",
              {done, result}, 6);

        // R9: restart abandons earlier units
        begin_op(2'b00, 2);
        send(8'h09, 8'h00, 0);
        ua[0] = 8'h00; ub[0] = 8'h05;
        do_op(2'b00, 1, 1, 0);
        expect_op("R9", 1, 1'b0);

        // R9: units while idle are ignored
        for (int i = 0; i < 3; i++) send(8'h00, 8'h09, 0);
        check(done == 1'b0 && result == 2'b01, "R9", "idle units", {done, result}, 1);

        // R9: a unit in the start cycle is ignored
        @(negedge clk);
        start = 1'b1; length = 7'd1; mode = 2'b00;
        unit_valid = 1'b1; a_unit = 8'h00; b_unit = 8'h09;
        @(negedge clk);
        start = 1'b0; unit_valid = 1'b0;
        check(done == 1'b0, "R9", "unit with start", done, 0);
        send(8'h08, 8'h02, 0);
        check(done == 1'b1 && result == 2'b10, "R9", "next unit counts", {done, result}, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule